// File: doc/BRIEF.md
# Flash Self-Programming Command Controller

This block lets running software reprogram its own program memory. Software first writes a command pattern into a small control register. A store strobe or load strobe that arrives within a few cycles then starts that command. The commands are: put a word into the temporary page buffer, clear that buffer, erase one page, write the buffered page, or return the configuration (lock or fuse) byte in place of a program-memory read. A command that is not used in time lapses by itself. The command bits clear themselves when the work is done.

Erase and page write are passed to a flash array model over a valid/ready command channel. A page write then streams the buffered words out over a valid/ready data channel. The array model reports the end of the cell operation on `flash_done`. The CPU halt output stays high from the start of an erase or write until that done pulse.

Back-pressure rules: once `cmd_valid` is high it stays high, with `cmd_erase` and `cmd_page` unchanged, until a cycle in which `cmd_ready` is high. Once `wd_valid` is high it stays high, with `wd_data` and `wd_last` unchanged, until a cycle in which `wd_ready` is high. Words go out in index order 0 to PAGE_WORDS-1, and `wd_last` marks the final word. `flash_done` has an effect only after the last transfer of the operation.

Top module: `selfprog_ctl`

## Requirements
- R1: The control register reads as `{3'b000, clr_buf[4], rd_cfg[3], pg_wr[2], pg_er[1], arm[0]}`. After reset it reads 0x00, `cpu_halt` is low and both valid outputs are low. After reset every temporary buffer word holds all ones.
- R2: A register write is accepted only when its low five bits are 10001, 01001, 00101, 00011 or 00001. The upper three bits of the written value are dropped. Any other value leaves the register and its window unchanged.
- R3: An accepted write at clock edge t opens a window. A store strobe sampled at edges t+1 to t+4 is accepted. If none is accepted, the register reads 0x00 after edge t+4. Every accepted write restarts the window.
- R4: With only `arm` set, an accepted store writes `st_data` into the buffer word `ptr_addr[4:1]`, and `ptr_addr[0]` is ignored. The register reads 0x00 in the cycle after the accepting edge.
- R5: With `clr_buf` set, an accepted store sets every buffer word to all ones and clears the register.
- R6: With `pg_er` set, an accepted store issues a command with `cmd_erase`=1 and `cmd_page`=`ptr_addr[10:5]`. From the next cycle until completion, `cpu_halt` is high and the register keeps its value.
- R7: With `pg_wr` set, an accepted store issues a command with `cmd_erase`=0 and `cmd_page`=`ptr_addr[10:5]`. The accepted command is followed by every buffer word in index order, with `wd_last` on the final word. `st_data` is ignored.
- R8: The command and word channels obey the back-pressure rules above.
- R9: With `rd_cfg` set, a load strobe in the cycles before edges t+1 to t+3 raises `ld_cfg_hit`. `ld_cfg_data` then equals `fuse_bits` when `ptr_addr[0]`=1 and `lock_bits` when it is 0, and the register clears at that edge. A later load gives no hit. A store strobe while `rd_cfg` is set has no effect.
- R10: A register write during an erase or write is ignored. A store or load strobe with the register unarmed, or after its window, has no effect.
- R11: Once `flash_done` is sampled after the final transfer, `cpu_halt` is low and the register reads 0x00 in the next cycle.
- R12: When an accepted register write and a store strobe share an edge, the write takes effect and the store is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write value |
| reg_rdata | output | 8 | Control register read value |
| st_stb | input | 1 | Store instruction strobe |
| ld_stb | input | 1 | Load instruction strobe |
| ptr_addr | input | ADDR_W | Byte address pointer |
| st_data | input | DW | Word supplied with a store |
| lock_bits | input | 8 | Lock byte |
| fuse_bits | input | 8 | Fuse byte |
| ld_cfg_hit | output | 1 | The load returns configuration data |
| ld_cfg_data | output | 8 | Configuration byte for the load |
| cpu_halt | output | 1 | CPU stall during erase or write |
| cmd_valid | output | 1 | Command offered to the array |
| cmd_ready | input | 1 | Array accepts the command |
| cmd_erase | output | 1 | 1 for erase, 0 for page write |
| cmd_page | output | ADDR_W-1-log2(PAGE_WORDS) | Page number |
| wd_valid | output | 1 | Page word offered |
| wd_ready | input | 1 | Array accepts the word |
| wd_data | output | DW | Page word |
| wd_last | output | 1 | Final word of the page |
| flash_done | input | 1 | Array operation finished |

## Verification
Buffer fills use random word indexes, random data and random values of `ptr_addr[0]`. The store lands at each position in the window and also one cycle past it. The page images that are later streamed out therefore separate in-window stores from late stores, and show whether the low pointer bit leaks into the index.

Page writes and erases run against a ready signal that is held back at random. The words must still arrive complete and in order under any stall pattern. Directed cases cover the following:
- each rejected pattern,
- a rejected write, which must not restart the window,
- a store in the same cycle as a write,
- a configuration load at the edge of its window and one cycle beyond it, with each value of the select bit.

// File: rtl/selfprog_pkg.sv
package selfprog_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_ISSUE,
    SQ_STREAM,
    SQ_WAIT
  } seq_state_t;

  typedef struct packed {
    logic clr_buf;
    logic rd_cfg;
    logic pg_wr;
    logic pg_er;
    logic arm;
  } ctl_bits_t;

  function automatic logic pattern_ok(input logic [4:0] p);
    return (p == 5'b10001) || (p == 5'b01001) || (p == 5'b00101) ||
           (p == 5'b00011) || (p == 5'b00001);
  endfunction

endpackage

// File: rtl/selfprog_cmd_reg.sv
module selfprog_cmd_reg
  import selfprog_pkg::*;
#(
  parameter int ARM_WIN = 4,
  parameter int LD_WIN  = 3
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      reg_we,
  input  logic [7:0] reg_wdata,
  input  logic      busy,
  input  logic      seq_done,
  input  logic      st_stb,
  input  logic      ld_stb,
  output ctl_bits_t bits,
  output logic      fire_fill,
  output logic      fire_clr,
  output logic      fire_er,
  output logic      fire_wr,
  output logic      ld_hit
);
  localparam int CNT_W    = $clog2(ARM_WIN + 1);
  localparam int LD_FLOOR = ARM_WIN - LD_WIN;

  logic [CNT_W-1:0] win_cnt;
  logic wr_ok;
  logic win_open;
  logic st_go;

  // A write is taken only when idle and only for one of the legal patterns.
  assign wr_ok    = reg_we && !busy && pattern_ok(reg_wdata[4:0]);
  // A write in the same cycle takes precedence over any strobe.
  assign win_open = bits.arm && !busy && !wr_ok && (win_cnt != '0);
  assign st_go    = win_open && st_stb && !bits.rd_cfg;

  assign fire_fill = st_go && !bits.clr_buf && !bits.pg_wr && !bits.pg_er;
  assign fire_clr  = st_go && bits.clr_buf;
  assign fire_er   = st_go && bits.pg_er;
  assign fire_wr   = st_go && bits.pg_wr;
  // The load window is shorter: only the first LD_WIN cycles count.
  assign ld_hit    = win_open && ld_stb && bits.rd_cfg && (int'(win_cnt) > LD_FLOOR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits    <= '0;
      win_cnt <= '0;
    end else if (wr_ok) begin
      bits    <= ctl_bits_t'(reg_wdata[4:0]);
      win_cnt <= CNT_W'(ARM_WIN);
    end else if (busy) begin
      if (seq_done) begin
        bits    <= '0;
        win_cnt <= '0;
      end
    end else if (bits.arm) begin
      if (fire_er || fire_wr) begin
        // Bits stay up for the length of the array operation.
        win_cnt <= '0;
      end else if (st_go || ld_hit) begin
        bits    <= '0;
        win_cnt <= '0;
      end else if (win_cnt <= CNT_W'(1)) begin
        bits    <= '0;
        win_cnt <= '0;
      end else begin
        win_cnt <= win_cnt - CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/selfprog_page_buf.sv
module selfprog_page_buf #(
  parameter int WORDS = 16,
  parameter int DW    = 16,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic             clr,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [DW-1:0]    rd_data
);
  logic [DW-1:0] word_q [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q[g] <= '1;
      end else if (clr) begin
        word_q[g] <= '1;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        word_q[g] <= wr_data;
      end
    end
  end

  assign rd_data = word_q[rd_idx];

endmodule

// File: rtl/selfprog_seq.sv
module selfprog_seq
  import selfprog_pkg::*;
#(
  parameter int WORDS  = 16,
  parameter int DW     = 16,
  parameter int PAGE_W = 6,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_er,
  input  logic              go_wr,
  input  logic [PAGE_W-1:0] page_in,
  input  logic              cmd_ready,
  input  logic              wd_ready,
  input  logic              flash_done,
  input  logic [DW-1:0]     buf_data,
  output logic              busy,
  output logic              seq_done,
  output logic              cmd_valid,
  output logic              cmd_erase,
  output logic [PAGE_W-1:0] cmd_page,
  output logic              wd_valid,
  output logic [DW-1:0]     wd_data,
  output logic              wd_last,
  output logic [IDX_W-1:0]  rd_idx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

  seq_state_t        state;
  logic              op_er;
  logic [PAGE_W-1:0] page_q;
  logic [IDX_W-1:0]  widx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= SQ_IDLE;
      op_er  <= 1'b0;
      page_q <= '0;
      widx   <= '0;
    end else begin
      case (state)
        SQ_IDLE: begin
          if (go_er || go_wr) begin
            op_er  <= go_er;
            page_q <= page_in;
            widx   <= '0;
            state  <= SQ_ISSUE;
          end
        end
        SQ_ISSUE: begin
          if (cmd_ready) state <= op_er ? SQ_WAIT : SQ_STREAM;
        end
        SQ_STREAM: begin
          if (wd_ready) begin
            if (widx == LAST_IDX) state <= SQ_WAIT;
            else                  widx  <= widx + IDX_W'(1);
          end
        end
        SQ_WAIT: begin
          if (flash_done) state <= SQ_IDLE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign busy      = (state != SQ_IDLE);
  assign seq_done  = (state == SQ_WAIT) && flash_done;
  assign cmd_valid = (state == SQ_ISSUE);
  assign cmd_erase = op_er;
  assign cmd_page  = page_q;
  assign wd_valid  = (state == SQ_STREAM);
  assign wd_data   = buf_data;
  assign wd_last   = wd_valid && (widx == LAST_IDX);
  assign rd_idx    = widx;

endmodule

// File: rtl/selfprog_ctl.sv
module selfprog_ctl
  import selfprog_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int PAGE_WORDS = 16,
  parameter int DW         = 16,
  parameter int ARM_WIN    = 4,
  parameter int LD_WIN     = 3,
  localparam int IDX_W  = $clog2(PAGE_WORDS),
  localparam int PAGE_W = ADDR_W - 1 - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              st_stb,
  input  logic              ld_stb,
  input  logic [ADDR_W-1:0] ptr_addr,
  input  logic [DW-1:0]     st_data,
  input  logic [7:0]        lock_bits,
  input  logic [7:0]        fuse_bits,
  output logic              ld_cfg_hit,
  output logic [7:0]        ld_cfg_data,
  output logic              cpu_halt,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic              cmd_erase,
  output logic [PAGE_W-1:0] cmd_page,
  output logic              wd_valid,
  input  logic              wd_ready,
  output logic [DW-1:0]     wd_data,
  output logic              wd_last,
  input  logic              flash_done
);
  ctl_bits_t        bits;
  logic             fire_fill, fire_clr, fire_er, fire_wr, ld_hit;
  logic             busy, seq_done;
  logic [IDX_W-1:0] rd_idx;
  logic [DW-1:0]    buf_data;
  logic [IDX_W-1:0] fill_idx;
  logic [PAGE_W-1:0] page_sel;

  // Bit 0 of the pointer picks a byte, so it is skipped for word selection.
  assign fill_idx = ptr_addr[IDX_W:1];
  assign page_sel = ptr_addr[ADDR_W-1:IDX_W+1];

  selfprog_cmd_reg #(.ARM_WIN(ARM_WIN), .LD_WIN(LD_WIN)) u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .busy      (busy),
    .seq_done  (seq_done),
    .st_stb    (st_stb),
    .ld_stb    (ld_stb),
    .bits      (bits),
    .fire_fill (fire_fill),
    .fire_clr  (fire_clr),
    .fire_er   (fire_er),
    .fire_wr   (fire_wr),
    .ld_hit    (ld_hit)
  );

  selfprog_page_buf #(.WORDS(PAGE_WORDS), .DW(DW)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (fire_fill),
    .wr_idx  (fill_idx),
    .wr_data (st_data),
    .clr     (fire_clr),
    .rd_idx  (rd_idx),
    .rd_data (buf_data)
  );

  selfprog_seq #(.WORDS(PAGE_WORDS), .DW(DW), .PAGE_W(PAGE_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .go_er      (fire_er),
    .go_wr      (fire_wr),
    .page_in    (page_sel),
    .cmd_ready  (cmd_ready),
    .wd_ready   (wd_ready),
    .flash_done (flash_done),
    .buf_data   (buf_data),
    .busy       (busy),
    .seq_done   (seq_done),
    .cmd_valid  (cmd_valid),
    .cmd_erase  (cmd_erase),
    .cmd_page   (cmd_page),
    .wd_valid   (wd_valid),
    .wd_data    (wd_data),
    .wd_last    (wd_last),
    .rd_idx     (rd_idx)
  );

  assign reg_rdata   = {3'b000, bits};
  assign cpu_halt    = busy;
  assign ld_cfg_hit  = ld_hit;
  assign ld_cfg_data = ld_hit ? (ptr_addr[0] ? fuse_bits : lock_bits) : 8'h00;

endmodule

// File: rtl/selfprog_ctl_chk.sv
module selfprog_ctl_chk
  import selfprog_pkg::*;
#(
  parameter int ARM_WIN = 4,
  parameter int PAGE_W  = 6,
  parameter int DW      = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [7:0]        reg_wdata,
  input logic [7:0]        reg_rdata,
  input logic              st_stb,
  input logic              ld_cfg_hit,
  input logic              cpu_halt,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              cmd_erase,
  input logic [PAGE_W-1:0] cmd_page,
  input logic              wd_valid,
  input logic              wd_ready,
  input logic [DW-1:0]     wd_data,
  input logic              wd_last,
  input logic              flash_done
);
  int unsigned armed_cycles;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_cycles <= 0;
    else if (reg_we && !cpu_halt && pattern_ok(reg_wdata[4:0])) armed_cycles <= 0;
    else if (reg_rdata[0] && !cpu_halt && armed_cycles < 255) armed_cycles <= armed_cycles + 1;
  end

  a_r2_legal_value: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[4:0] inside {5'b00000, 5'b10001, 5'b01001, 5'b00101, 5'b00011, 5'b00001});

  a_r3_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
    armed_cycles <= ARM_WIN);

  a_r6_halt_holds_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_halt |-> (reg_rdata[0] && (reg_rdata[1] || reg_rdata[2])));

  a_r8_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_page) && $stable(cmd_erase)));

  a_r8_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_valid && !wd_ready) |=> (wd_valid && $stable(wd_data) && $stable(wd_last)));

  a_r9_load_armed: assert property (@(posedge clk) disable iff (!rst_n)
    ld_cfg_hit |-> (reg_rdata[3] && reg_rdata[0] && !cpu_halt));

  a_r10_busy_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_halt && reg_we && !flash_done) |=> $stable(reg_rdata));

  a_r11_release: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_halt && flash_done && !cmd_valid && !wd_valid) |=> (!cpu_halt && reg_rdata == 8'h00));

endmodule

bind selfprog_ctl selfprog_ctl_chk #(.ARM_WIN(ARM_WIN), .PAGE_W(PAGE_W), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_we     (reg_we),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .st_stb     (st_stb),
  .ld_cfg_hit (ld_cfg_hit),
  .cpu_halt   (cpu_halt),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_erase  (cmd_erase),
  .cmd_page   (cmd_page),
  .wd_valid   (wd_valid),
  .wd_ready   (wd_ready),
  .wd_data    (wd_data),
  .wd_last    (wd_last),
  .flash_done (flash_done)
);

// File: tb/selfprog_ctl_test.sv
module selfprog_ctl_test;
  localparam int AW = 11;
  localparam int PW = 16;
  localparam int DW = 16;
  localparam int PGW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic st_stb = 1'b0, ld_stb = 1'b0;
  logic [AW-1:0] ptr_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic [7:0] lock_bits = 8'h3C, fuse_bits = 8'hA5;
  logic ld_cfg_hit;
  logic [7:0] ld_cfg_data;
  logic cpu_halt, cmd_valid, cmd_erase, wd_valid, wd_last;
  logic cmd_ready = 1'b0, wd_ready = 1'b0, flash_done = 1'b0;
  logic [PGW-1:0] cmd_page;
  logic [DW-1:0] wd_data;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  logic [DW-1:0] exp_buf [PW];

  always #5 clk = ~clk;

  selfprog_ctl uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .st_stb(st_stb), .ld_stb(ld_stb), .ptr_addr(ptr_addr), .st_data(st_data),
    .lock_bits(lock_bits), .fuse_bits(fuse_bits), .ld_cfg_hit(ld_cfg_hit),
    .ld_cfg_data(ld_cfg_data), .cpu_halt(cpu_halt), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_erase(cmd_erase), .cmd_page(cmd_page),
    .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data), .wd_last(wd_last),
    .flash_done(flash_done)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog R11: actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [7:0] v);
    reg_we = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic store(input logic [AW-1:0] p, input logic [DW-1:0] d);
    st_stb = 1'b1; ptr_addr = p; st_data = d;
    @(negedge clk);
    st_stb = 1'b0;
  endtask

  function automatic logic [AW-1:0] mk_ptr(input int pg, input int idx, input bit lo);
    return {pg[PGW-1:0], idx[3:0], lo};
  endfunction

  // Act as the array model after a store that started an erase or a write.
  task automatic serve(input bit er, input int pg, input logic [7:0] bits_exp);
    bit got = 1'b0;
    int widx = 0;
    check(cpu_halt === 1'b1, "R6", "halt after start", cpu_halt, 1);
    while (!got) begin
      cmd_ready = ($urandom % 3) != 0;
      #1;
      if (cmd_valid && cmd_ready) begin
        check(cmd_erase == er, er ? "R6" : "R7", "cmd_erase", cmd_erase, er);
        check(cmd_page == pg[PGW-1:0], er ? "R6" : "R7", "cmd_page", cmd_page, pg);
        got = 1'b1;
      end
      @(negedge clk);
    end
    cmd_ready = 1'b0;
    if (!er) begin
      while (widx < PW) begin
        wd_ready = ($urandom % 3) != 0;
        #1;
        if (wd_valid && wd_ready) begin
          check(wd_data == exp_buf[widx], "R7", $sformatf("word %0d", widx), wd_data, exp_buf[widx]);
          check(wd_last == (widx == PW - 1), "R8", "wd_last", wd_last, widx == PW - 1);
          widx++;
        end
        @(negedge clk);
      end
      wd_ready = 1'b0;
    end
    reg_we = 1'b1; reg_wdata = 8'h01;
    @(negedge clk);
    reg_we = 1'b0;
    idle(1);
    check(cpu_halt === 1'b1, "R6", "halt held", cpu_halt, 1);
    check(reg_rdata == bits_exp, "R10", "reg during busy", reg_rdata, bits_exp);
    flash_done = 1'b1;
    @(negedge clk);
    flash_done = 1'b0;
    check(cpu_halt === 1'b0, "R11", "halt released", cpu_halt, 0);
    check(reg_rdata == 8'h00, "R11", "reg cleared", reg_rdata, 0);
  endtask

  task automatic page_write(input int pg, input int k);
    wr_reg(8'h05);
    idle(k);
    store(mk_ptr(pg, $urandom % PW, $urandom % 2), DW'($urandom));
    serve(1'b0, pg, 8'h05);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < PW; i++) exp_buf[i] = '1;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(reg_rdata == 8'h00, "R1", "reset reg", reg_rdata, 0);
    check(!cpu_halt && !cmd_valid && !wd_valid, "R1", "reset outputs",
          {cpu_halt, cmd_valid, wd_valid}, 0);

    // R2 illegal patterns are dropped
    wr_reg(8'h13);
    check(reg_rdata == 8'h00, "R2", "illegal 10011", reg_rdata, 0);
    wr_reg(8'h07);
    check(reg_rdata == 8'h00, "R2", "illegal 00111", reg_rdata, 0);
    wr_reg(8'hE1);
    check(reg_rdata == 8'h01, "R2", "reserved bits dropped", reg_rdata, 1);
    // R3 expiry after four cycles
    idle(3);
    check(reg_rdata == 8'h01, "R3", "armed at t+3", reg_rdata, 1);
    idle(1);
    check(reg_rdata == 8'h00, "R3", "expired at t+4", reg_rdata, 0);

    // R2 a rejected write does not restart the window
    wr_reg(8'h01); idle(1); wr_reg(8'h1F); idle(1);
    check(reg_rdata == 8'h01, "R2", "still armed", reg_rdata, 1);
    idle(1);
    check(reg_rdata == 8'h00, "R2", "no restart", reg_rdata, 0);
    // R3 an accepted write restarts it
    wr_reg(8'h01); idle(1); wr_reg(8'h01); idle(3);
    check(reg_rdata == 8'h01, "R3", "restarted", reg_rdata, 1);
    idle(1);
    check(reg_rdata == 8'h00, "R3", "restart expiry", reg_rdata, 0);

    // R4 fill on the last window cycle, with bit 0 of the pointer set
    wr_reg(8'h01); idle(3);
    store(mk_ptr(9, 5, 1), 16'hBEEF);
    exp_buf[5] = 16'hBEEF;
    check(reg_rdata == 8'h00, "R4", "arm cleared after fill", reg_rdata, 0);
    // R10 a store one cycle late is dropped
    wr_reg(8'h01); idle(4);
    store(mk_ptr(9, 6, 0), 16'h1111);
    // R10 a store with nothing armed is dropped
    store(mk_ptr(9, 7, 0), 16'h2222);
    // R12 a write and a store in the same cycle
    wr_reg(8'h01);
    reg_we = 1'b1; reg_wdata = 8'h01; st_stb = 1'b1; ptr_addr = mk_ptr(0, 8, 0); st_data = 16'h3333;
    @(negedge clk);
    reg_we = 1'b0; st_stb = 1'b0;
    check(reg_rdata == 8'h01, "R12", "write wins", reg_rdata, 1);
    idle(4);
    page_write(12, 2);

    // R9 configuration loads
    wr_reg(8'h09);
    ld_stb = 1'b1; ptr_addr = 11'd1; #1;
    check(ld_cfg_hit && ld_cfg_data == fuse_bits, "R9", "fuse read", ld_cfg_data, fuse_bits);
    @(negedge clk); ld_stb = 1'b0;
    check(reg_rdata == 8'h00, "R9", "cleared after load", reg_rdata, 0);
    wr_reg(8'h09); idle(2);
    ld_stb = 1'b1; ptr_addr = 11'd0; #1;
    check(ld_cfg_hit && ld_cfg_data == lock_bits, "R9", "lock read at t+3", ld_cfg_data, lock_bits);
    @(negedge clk); ld_stb = 1'b0;
    wr_reg(8'h09);
    store(mk_ptr(0, 2, 0), 16'h4444);
    check(reg_rdata == 8'h09 && !cpu_halt, "R9", "store ignored", reg_rdata, 9);
    idle(2);
    ld_stb = 1'b1; #1;
    check(!ld_cfg_hit, "R9", "late load", ld_cfg_hit, 0);
    @(negedge clk); ld_stb = 1'b0;
    check(reg_rdata == 8'h00, "R9", "expired", reg_rdata, 0);

    // R6 erase
    wr_reg(8'h03); idle(1);
    store(mk_ptr(33, 3, 1), 16'h0);
    serve(1'b1, 33, 8'h03);

    // R5 buffer clear
    wr_reg(8'h11); idle(2);
    store(mk_ptr(0, 0, 0), 16'h0);
    for (int i = 0; i < PW; i++) exp_buf[i] = '1;
    check(reg_rdata == 8'h00, "R5", "reg after clear", reg_rdata, 0);
    page_write(1, 0);

    // R4 R7 R8 random fills, checked through page writes under back-pressure
    for (int it = 0; it < 90; it++) begin
      int k = $urandom % 6;
      int ix = $urandom % PW;
      logic [DW-1:0] d = DW'($urandom);
      if ($urandom % 8 == 0) wr_reg(8'h0F);
      wr_reg(8'h01);
      idle(k);
      store(mk_ptr($urandom % 64, ix, $urandom % 2), d);
      if (k <= 3) exp_buf[ix] = d;
      check(reg_rdata == 8'h00, "R4", "arm after store", reg_rdata, 0);
      if (it % 15 == 14) page_write($urandom % 64, $urandom % 4);
      if (it == 50) begin
        wr_reg(8'h11); store(mk_ptr(0, 0, 0), 16'h0);
        for (int i = 0; i < PW; i++) exp_buf[i] = '1;
      end
    end
    page_write(63, 3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule